// File: doc/BRIEF.md
# Multi-Mode Polarity Timer

A 16-bit timer peripheral built around three data registers: a running count, a reload limit, and a PWM/compare value. It also has a control word. A three-bit mode code picks one of eight behaviours: one-shot, continuous, counter, PWM single output, capture, compare, gated, and capture/compare. A single polarity bit in the control word does different jobs depending on the mode:

- it sets the level the output rests at;
- it chooses which input edge counts or captures;
- in gated mode, it chooses the input level that enables counting.

Software uses a simple write/read register port. The timer input pin is assumed to be already synchronous to the system clock. Input edges are found by comparing each sample with the sample from the previous clock.

A reload happens when the count equals the reload value on a counting step. On a reload the count returns to 1 and the interrupt output pulses. In most modes the output pin also inverts at each reload. In PWM mode the output inverts on a compare match and is restored at reload. Capture events copy the running count into the PWM/compare register and also raise the interrupt.

Top module: `polarity_timer`

## Requirements
- R1: While the enable bit is 0, `tout_o` equals the polarity bit. After reset the control word is 0, so `tout_o` reads 0.
- R2: A reload occurs when the count equals the reload register at a counting step. The count then becomes 1, and `irq_o` is high for the following cycle only, unless another event occurs.
- R3: One-shot mode (code 0) behaves as follows at a reload:
  - the enable bit clears;
  - `tout_o` shows the inverse of polarity for exactly one cycle, then returns to polarity;
  - the count then holds.
- R4: In continuous (code 1), counter (2), capture (4), compare (5), gated (6) and capture/compare (7) modes, `tout_o` inverts at every reload. In modes that count every cycle, the count advances by one per clock.
- R5: Counter mode (code 2) counts only on input edges. With polarity 0 it counts rising edges; with polarity 1 it counts falling edges. The other edge and steady levels leave the count unchanged.
- R6: PWM mode (code 3) starts with `tout_o` at polarity. When the count equals the PWM/compare register, `tout_o` becomes the inverse of polarity. At reload it returns to polarity.
- R7: Capture mode (code 4) counts every cycle. On the active input edge (rising for polarity 0, falling for polarity 1), it copies the count held before that edge into the PWM/compare register and pulses `irq_o`. The other edge changes neither.
- R8: Gated mode (code 6) counts only while the input sits at its active level: high for polarity 0, low for polarity 1. When the input leaves that level (a falling edge for polarity 0, a rising edge for polarity 1), `irq_o` pulses.
- R9: Capture/compare mode (code 7) holds the count until the first active edge (rising for polarity 0, falling for polarity 1). Counting starts on the cycle after that edge, and that first edge captures nothing. Each later active edge captures the count into the PWM/compare register and pulses `irq_o`.
- R10: The register map is as follows. Every register reads back what was last written unless the hardware has updated it.

  | Address | Register |
  |---------|----------|
  | 0 | count |
  | 1 | reload |
  | 2 | PWM/compare |
  | 3 | control |

  The control word holds the mode code in bits [2:0], polarity in bit 6 and enable in bit 7. A write to the control word returns the output to the new polarity level and clears the capture/compare start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | W | Write data |
| reg_rdata_o | output | W | Read data for the selected register (combinational) |
| tin_i | input | 1 | Timer input, already synchronous |
| tout_o | output | 1 | Timer output |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench uses the default width of 16 and programs reload limits between 2 and 1000. This brings each reload, toggle and one-shot expiry within a handful of cycles, so every mode is exercised in well under a thousand clocks. The input pin is driven at falling clock edges, and each capture is predicted from the count read just before the edge. This confirms that captures take the pre-increment value. Both polarity settings are run in counter, capture and gated modes to cover the edge and level reinterpretation.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [2:0] {
    M_ONESHOT = 3'd0,
    M_CONT    = 3'd1,
    M_COUNTER = 3'd2,
    M_PWM     = 3'd3,
    M_CAPTURE = 3'd4,
    M_COMPARE = 3'd5,
    M_GATED   = 3'd6,
    M_CAPCMP  = 3'd7
  } tmode_e;

  localparam logic [1:0] A_COUNT  = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_CMP    = 2'd2;
  localparam logic [1:0] A_CTRL   = 2'd3;

  localparam int MODE_W  = 3;
  localparam int POL_BIT = 6;
  localparam int EN_BIT  = 7;

  // Modes in which the output inverts at each reload
  function automatic logic toggles_on_reload(input tmode_e m);
    return !(m == M_ONESHOT || m == M_PWM);
  endfunction

endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic pol_i,
  output logic act_edge_o,
  output logic inact_edge_o,
  output logic act_level_o
);
  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_w       = sig_i & ~prev_q;
  assign fall_w       = ~sig_i & prev_q;
  assign act_edge_o   = pol_i ? fall_w : rise_w;
  assign inact_edge_o = pol_i ? rise_w : fall_w;
  assign act_level_o  = sig_i ^ pol_i;
endmodule

// File: rtl/ptmr_sched.sv
module ptmr_sched
  import ptmr_pkg::*;
(
  input  tmode_e mode_i,
  input  logic   en_i,
  input  logic   armed_i,
  input  logic   act_edge_i,
  input  logic   inact_edge_i,
  input  logic   act_level_i,
  input  logic   at_reload_i,
  input  logic   at_cmp_i,
  output logic   tick_o,
  output logic   reload_evt_o,
  output logic   match_evt_o,
  output logic   capture_evt_o,
  output logic   arm_evt_o,
  output logic   gate_end_evt_o
);
  logic step_w;

  always_comb begin
    unique case (mode_i)
      M_COUNTER: step_w = act_edge_i;
      M_GATED:   step_w = act_level_i;
      M_CAPCMP:  step_w = armed_i;
      default:   step_w = 1'b1;
    endcase
  end

  assign tick_o         = en_i & step_w;
  assign reload_evt_o   = tick_o & at_reload_i;
  assign match_evt_o    = tick_o & at_cmp_i & (mode_i == M_PWM);
  assign capture_evt_o  = en_i & act_edge_i &
                          ((mode_i == M_CAPTURE) || (mode_i == M_CAPCMP && armed_i));
  assign arm_evt_o      = en_i & act_edge_i & (mode_i == M_CAPCMP) & ~armed_i;
  assign gate_end_evt_o = en_i & inact_edge_i & (mode_i == M_GATED);
endmodule

// File: rtl/ptmr_outgen.sv
module ptmr_outgen
  import ptmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode_i,
  input  logic   en_i,
  input  logic   pol_i,
  input  logic   init_i,
  input  logic   init_pol_i,
  input  logic   reload_evt_i,
  input  logic   match_evt_i,
  output logic   tout_o
);
  logic out_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= reload_evt_i & (mode_i == M_ONESHOT);
      if (init_i)
        out_q <= init_pol_i;
      else if (reload_evt_i) begin
        if (mode_i == M_PWM)                out_q <= pol_i;
        else if (toggles_on_reload(mode_i)) out_q <= ~out_q;
      end else if (match_evt_i)
        out_q <= ~pol_i;
    end
  end

  assign tout_o = pulse_q ? ~pol_i : (en_i ? out_q : pol_i);
endmodule

// File: rtl/polarity_timer.sv
module polarity_timer
  import ptmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         tin_i,
  output logic         tout_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] count_step(input logic [W-1:0] c);
    return c + ONE;
  endfunction

  function automatic logic [W-1:0] ctrl_expire(input logic [W-1:0] c);
    logic [W-1:0] r;
    r         = c;
    r[EN_BIT] = 1'b0;
    return r;
  endfunction

  logic [W-1:0] count_q, reload_q, cmp_q, ctrl_q;
  logic         armed_q, irq_q;

  logic   en_w, pol_w;
  tmode_e mode_w;
  logic   count_wr_w, reload_wr_w, cmp_wr_w, ctrl_wr_w;
  logic   act_edge_w, inact_edge_w, act_level_w;
  logic   tick_w, reload_evt_w, match_evt_w, capture_evt_w, arm_evt_w, gate_end_w;
  logic   init_w, init_pol_w;

  assign en_w   = ctrl_q[EN_BIT];
  assign pol_w  = ctrl_q[POL_BIT];
  assign mode_w = tmode_e'(ctrl_q[MODE_W-1:0]);

  assign count_wr_w  = reg_wr_i && reg_addr_i == A_COUNT;
  assign reload_wr_w = reg_wr_i && reg_addr_i == A_RELOAD;
  assign cmp_wr_w    = reg_wr_i && reg_addr_i == A_CMP;
  assign ctrl_wr_w   = reg_wr_i && reg_addr_i == A_CTRL;

  ptmr_edge edge_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_i        (tin_i),
    .pol_i        (pol_w),
    .act_edge_o   (act_edge_w),
    .inact_edge_o (inact_edge_w),
    .act_level_o  (act_level_w)
  );

  ptmr_sched sched_i (
    .mode_i         (mode_w),
    .en_i           (en_w),
    .armed_i        (armed_q),
    .act_edge_i     (act_edge_w),
    .inact_edge_i   (inact_edge_w),
    .act_level_i    (act_level_w),
    .at_reload_i    (count_q == reload_q),
    .at_cmp_i       (count_q == cmp_q),
    .tick_o         (tick_w),
    .reload_evt_o   (reload_evt_w),
    .match_evt_o    (match_evt_w),
    .capture_evt_o  (capture_evt_w),
    .arm_evt_o      (arm_evt_w),
    .gate_end_evt_o (gate_end_w)
  );

  assign init_w     = ctrl_wr_w | ~en_w;
  assign init_pol_w = ctrl_wr_w ? reg_wdata_i[POL_BIT] : pol_w;

  ptmr_outgen out_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_w),
    .en_i         (en_w),
    .pol_i        (pol_w),
    .init_i       (init_w),
    .init_pol_i   (init_pol_w),
    .reload_evt_i (reload_evt_w),
    .match_evt_i  (match_evt_w),
    .tout_o       (tout_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      ctrl_q   <= '0;
      armed_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (count_wr_w)        count_q <= reg_wdata_i;
      else if (reload_evt_w) count_q <= ONE;
      else if (tick_w)       count_q <= count_step(count_q);

      if (reload_wr_w) reload_q <= reg_wdata_i;

      if (cmp_wr_w)           cmp_q <= reg_wdata_i;
      else if (capture_evt_w) cmp_q <= count_q;

      if (ctrl_wr_w)                                  ctrl_q <= reg_wdata_i;
      else if (reload_evt_w && mode_w == M_ONESHOT)   ctrl_q <= ctrl_expire(ctrl_q);

      if (init_w)         armed_q <= 1'b0;
      else if (arm_evt_w) armed_q <= 1'b1;

      irq_q <= reload_evt_w | capture_evt_w | gate_end_w;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_COUNT:  reg_rdata_o = count_q;
      A_RELOAD: reg_rdata_o = reload_q;
      A_CMP:    reg_rdata_o = cmp_q;
      default:  reg_rdata_o = ctrl_q;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tout_o,
  input logic         irq_o,
  input logic [W-1:0] count_q,
  input logic         en_w,
  input logic         pol_w,
  input tmode_e       mode_w,
  input logic         ctrl_wr_w,
  input logic         count_wr_w,
  input logic         reload_evt_w,
  input logic         match_evt_w,
  input logic         capture_evt_w,
  input logic         gate_end_w
);
  // R1
  disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !$past(reload_evt_w && mode_w == M_ONESHOT)) |-> tout_o == pol_w);

  // R2
  reload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt_w && !count_wr_w) |=> count_q == W'(1));

  // R2
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(reload_evt_w || capture_evt_w || gate_end_w));

  // R2
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt_w || capture_evt_w || gate_end_w) |=> irq_o);

  // R3
  oneshot_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt_w && mode_w == M_ONESHOT && !ctrl_wr_w) |=> (!en_w && tout_o != pol_w));

  // R4
  reload_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt_w && toggles_on_reload(mode_w) && !ctrl_wr_w) |=> tout_o != $past(tout_o));

  // R6
  pwm_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt_w && mode_w == M_PWM && !ctrl_wr_w) |=> tout_o == pol_w);

  // R6
  pwm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt_w && !reload_evt_w && !ctrl_wr_w) |=> tout_o != pol_w);
endmodule

bind polarity_timer ptmr_chk #(.W(W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tout_o        (tout_o),
  .irq_o         (irq_o),
  .count_q       (count_q),
  .en_w          (en_w),
  .pol_w         (pol_w),
  .mode_w        (mode_w),
  .ctrl_wr_w     (ctrl_wr_w),
  .count_wr_w    (count_wr_w),
  .reload_evt_w  (reload_evt_w),
  .match_evt_w   (match_evt_w),
  .capture_evt_w (capture_evt_w),
  .gate_end_w    (gate_end_w)
);

// File: tb/polarity_timer_tb_top.sv
`timescale 1ns/1ps
module polarity_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         tin = 1'b0;
  logic         tout;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  polarity_timer #(.W(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .tin_i       (tin),
    .tout_o      (tout),
    .irq_o       (irq)
  );

  function automatic logic [W-1:0] ctl(input bit en, input bit pol, input int mode);
    return W'((int'(en) << 7) | (int'(pol) << 6) | (mode & 7));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input longint exp);
    logic [W-1:0] v;
    rd(a, v);
    chk_eq(req, v, exp);
  endtask

  task automatic t_reset_and_regs();
    chk_eq("R1 reset tout", tout, 0);
    chk_eq("R2 reset irq", irq, 0);
    chk_reg("R10 reset count", 2'd0, 0);
    chk_reg("R10 reset ctrl", 2'd3, 0);
    wr(2'd1, 16'h1234);
    chk_reg("R10 reload readback", 2'd1, 16'h1234);
    wr(2'd2, 16'hBEEF);
    chk_reg("R10 cmp readback", 2'd2, 16'hBEEF);
    wr(2'd3, ctl(0, 1, 5));
    chk_reg("R10 ctrl readback", 2'd3, ctl(0, 1, 5));
    chk_eq("R1 disabled tout follows pol=1", tout, 1);
    wr(2'd3, ctl(0, 0, 5));
    chk_eq("R1 disabled tout follows pol=0", tout, 0);
  endtask

  task automatic t_continuous();
    wr(2'd3, 0); wr(2'd1, 4); wr(2'd0, 1);
    wr(2'd3, ctl(1, 0, 1));
    step(2);
    chk_reg("R4 count advances", 2'd0, 3);
    chk_eq("R4 tout before reload", tout, 0);
    step(1);
    chk_reg("R2 count at limit", 2'd0, 4);
    chk_eq("R2 no irq before reload", irq, 0);
    step(1);
    chk_reg("R2 count back to 1", 2'd0, 1);
    chk_eq("R2 irq at reload", irq, 1);
    chk_eq("R4 tout toggled high", tout, 1);
    step(1);
    chk_eq("R2 irq one cycle", irq, 0);
    step(3);
    chk_eq("R4 tout toggled low", tout, 0);
  endtask

  task automatic t_compare();
    wr(2'd3, 0); wr(2'd1, 2); wr(2'd0, 1);
    wr(2'd3, ctl(1, 0, 5));
    step(1);
    chk_eq("R4 compare tout before", tout, 0);
    step(1);
    chk_eq("R4 compare tout toggled", tout, 1);
    chk_eq("R2 compare irq", irq, 1);
  endtask

  task automatic t_oneshot();
    wr(2'd3, 0); wr(2'd1, 3); wr(2'd0, 1);
    wr(2'd3, ctl(1, 0, 0));
    step(2);
    chk_eq("R3 tout idle", tout, 0);
    step(1);
    chk_eq("R3 tout pulse", tout, 1);
    chk_eq("R3 irq", irq, 1);
    chk_reg("R3 enable cleared", 2'd3, ctl(0, 0, 0));
    step(1);
    chk_eq("R3 tout back", tout, 0);
    step(2);
    chk_reg("R3 count holds", 2'd0, 1);
    chk_eq("R3 tout stays", tout, 0);
  endtask

  task automatic t_counter();
    tin = 0;
    wr(2'd3, 0); wr(2'd1, 100); wr(2'd0, 0);
    wr(2'd3, ctl(1, 0, 2));
    step(3);
    chk_reg("R5 no count on steady input", 2'd0, 0);
    tin = 1; step(1);
    chk_reg("R5 rising counts pol0", 2'd0, 1);
    step(2);
    chk_reg("R5 high level no count", 2'd0, 1);
    tin = 0; step(1);
    chk_reg("R5 falling ignored pol0", 2'd0, 1);
    tin = 1; step(1);
    chk_reg("R5 second rising", 2'd0, 2);
    wr(2'd3, ctl(1, 1, 2));
    tin = 0; step(1);
    chk_reg("R5 falling counts pol1", 2'd0, 3);
    tin = 1; step(1);
    chk_reg("R5 rising ignored pol1", 2'd0, 3);
  endtask

  task automatic t_pwm();
    wr(2'd3, 0); wr(2'd1, 6); wr(2'd2, 3); wr(2'd0, 1);
    wr(2'd3, ctl(1, 0, 3));
    step(2);
    chk_eq("R6 tout before match", tout, 0);
    step(1);
    chk_eq("R6 tout after match", tout, 1);
    step(2);
    chk_eq("R6 tout held", tout, 1);
    step(1);
    chk_eq("R6 tout restored at reload", tout, 0);
    chk_reg("R6 count reloaded", 2'd0, 1);
  endtask

  task automatic t_capture();
    logic [W-1:0] c;
    tin = 0;
    wr(2'd3, 0); wr(2'd1, 1000); wr(2'd2, 0); wr(2'd0, 1);
    wr(2'd3, ctl(1, 0, 4));
    step(4);
    rd(2'd0, c);
    tin = 1; step(1);
    chk_eq("R7 irq on rising capture", irq, 1);
    chk_reg("R7 captured value", 2'd2, c);
    step(2);
    tin = 0; step(1);
    chk_eq("R7 falling no irq pol0", irq, 0);
    chk_reg("R7 falling no capture pol0", 2'd2, c);
    wr(2'd3, ctl(1, 1, 4));
    step(2);
    tin = 1; step(1);
    chk_eq("R7 rising no irq pol1", irq, 0);
    chk_reg("R7 rising no capture pol1", 2'd2, c);
    rd(2'd0, c);
    tin = 0; step(1);
    chk_eq("R7 irq falling pol1", irq, 1);
    chk_reg("R7 captured falling pol1", 2'd2, c);
  endtask

  task automatic t_gated();
    tin = 0;
    wr(2'd3, 0); wr(2'd1, 1000); wr(2'd0, 0);
    wr(2'd3, ctl(1, 0, 6));
    step(3);
    chk_reg("R8 no count while low pol0", 2'd0, 0);
    tin = 1; step(1);
    chk_reg("R8 counts while high", 2'd0, 1);
    chk_eq("R8 no irq on rising pol0", irq, 0);
    step(2);
    chk_reg("R8 keeps counting", 2'd0, 3);
    tin = 0; step(1);
    chk_reg("R8 stops on low", 2'd0, 3);
    chk_eq("R8 irq on falling pol0", irq, 1);
    step(1);
    chk_eq("R8 irq one cycle", irq, 0);
    wr(2'd3, ctl(1, 1, 6));
    step(2);
    chk_reg("R8 counts while low pol1", 2'd0, 5);
    tin = 1; step(1);
    chk_reg("R8 stops high pol1", 2'd0, 5);
    chk_eq("R8 irq on rising pol1", irq, 1);
  endtask

  task automatic t_capcmp();
    tin = 0;
    wr(2'd3, 0); wr(2'd1, 1000); wr(2'd2, 0); wr(2'd0, 0);
    wr(2'd3, ctl(1, 0, 7));
    step(3);
    chk_reg("R9 idle before first edge", 2'd0, 0);
    tin = 1; step(1);
    chk_reg("R9 arming edge no step", 2'd0, 0);
    chk_eq("R9 arming edge no irq", irq, 0);
    chk_reg("R9 arming edge no capture", 2'd2, 0);
    step(3);
    chk_reg("R9 counting after arm", 2'd0, 3);
    tin = 0; step(1);
    chk_eq("R9 falling no irq", irq, 0);
    tin = 1; step(1);
    chk_reg("R9 capture on second rising", 2'd2, 4);
    chk_eq("R9 irq on capture", irq, 1);
    chk_reg("R9 count continues", 2'd0, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_regs();
    t_continuous();
    t_compare();
    t_oneshot();
    t_counter();
    t_pwm();
    t_capture();
    t_gated();
    t_capcmp();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule